// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets a host microcontroller read and write a small byte-wide register file and issue command strobes to neighbouring logic. The host drives a select line (active low), a serial clock and a data line; the block answers on its own data line. Every word is eight bits long, shifted most significant bit first. The serial clock is oversampled in the system clock domain, so the block has a single clock.

A transaction starts when select falls. Its first byte is a framing byte. Bit 7 chooses a command (1) or a register access (0). For a register access, bit 6 chooses read (1) or write (0), and bit 5 chooses burst mode (1) or paired mode (0). Bits 4:0 hold the register address or the command code. In paired mode the stream alternates framing and data bytes. In burst mode a single start address is followed by any number of data bytes, and the address steps after each one. In command mode the command byte raises a one-cycle strobe. Each later byte in the same transaction is either another command (bit 7 set) or an argument byte.

A transaction ends, and any partial byte is dropped, when select rises. The register storage sits inside the block so that reads and writes can be observed through the serial port.

Top module: `serial_reg_port`

## Requirements
- R1: Words are 8 bits, shifted MSB first on both data lines. A byte written to a register reads back identical.
- R2: Select going high discards any partial byte and any unfinished access. The next byte after select falls again is treated as a framing byte.
- R3: In the framing byte, bit 7=1 means command, bit 6=1 means read, bit 5=1 means burst, and bits 4:0 give the address or code. On a command byte, bits 6 and 5 are ignored.
- R4: In paired write mode, each framing byte is followed by one data byte, which is stored at that framing byte's address.
- R5: In paired read mode, the byte after the framing byte returns the addressed register on the slave output. The slave changes its output after falling clock edges, so each bit is valid at the next rising edge.
- R6: In burst write mode, consecutive data bytes go to consecutive addresses starting at the framing address.
- R7: The burst address wraps from 31 to 0.
- R8: In burst read mode, consecutive bytes return consecutive registers starting at the framing address.
- R9: A command byte produces exactly one cycle of cmd_stb, with cmd_code equal to its bits 4:0.
- R10: After a command byte in the same transaction, a byte with bit 7 set gives another command strobe. Any other byte gives one cycle of arg_stb, with arg_byte equal to that byte.
- R11: The host data line is ignored during read data bytes: no register changes, whatever value is on it.
- R12: After reset, all registers read 0, the slave output is 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel_n | input | 1 | Transaction select, active low |
| spi_clk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 5 | Command code, valid with cmd_stb |
| arg_stb | output | 1 | One-cycle argument strobe |
| arg_byte | output | 8 | Argument byte, valid with arg_stb |

## Verification
Some properties are checked on every cycle. Deselecting clears the bit counter, the transmit register and the framing phase. Command and argument strobes never coincide and never last past one cycle. No write happens in a read data byte. The burst address steps by exactly one, with wrap, on each data byte. The transmit register holds still between serial clock edges.

Other behaviour is shown only by the scenarios, all checked end to end at the serial pins. These cover MSB-first byte order across real transfers and the paired, burst and wrapping access sequences. They also cover the handling of command and argument bytes, recovery after an aborted partial byte, and the fact that host data is ignored during reads.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_DATA  = 2'd1,
    PH_CMD   = 2'd2
  } phase_t;

  typedef struct packed {
    logic       is_cmd;
    logic       rd;
    logic       burst;
    logic [4:0] field;
  } frame_t;

  // Split a framing byte into its control bits and address/code field.
  function automatic frame_t decode_frame(input logic [BYTE_W-1:0] b);
    frame_t f;
    f.is_cmd = b[7];
    f.rd     = b[6];
    f.burst  = b[5];
    f.field  = b[4:0];
    return f;
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int           W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] sh_in;
  logic [BYTE_W-1:0] sh_out;

  assign rise      = sclk_s & ~sclk_d & ~sel_n;
  assign fall      = ~sclk_s & sclk_d & ~sel_n;
  assign byte_done = rise && (cnt == CNT_W'(BYTE_W - 1));
  assign rx_byte   = {sh_in, mosi_s};
  assign miso      = sh_out[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt    <= '0;
      sh_in  <= '0;
      sh_out <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (sel_n)     cnt <= '0;
      else if (rise) cnt <= cnt + 1'b1;
      if (rise) sh_in <= {sh_in[BYTE_W-3:0], mosi_s};
      // The fall right after a byte boundary (cnt wrapped to 0) must not
      // disturb the freshly loaded byte.
      if (sel_n)                   sh_out <= '0;
      else if (load)               sh_out <= load_byte;
      else if (fall && cnt != '0)  sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
    end
  end

  a_r2_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (cnt == '0));
  a_r12_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (sh_out == '0));
  a_r5_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rise && !fall) |=> $stable(sh_out));
endmodule

// File: rtl/srp_store.sv
module srp_store
  import srp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][BYTE_W-1:0] regs;

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   q <= '0;
      else if (we && waddr == IDX)  q <= wdata;
    end
    assign regs[i] = q;
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              cmd_stb,
  output logic [4:0]        cmd_code,
  output logic              arg_stb,
  output logic [BYTE_W-1:0] arg_byte
);
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  phase_t            phase;
  logic [ADDR_W-1:0] addr;
  logic              rd, burst;
  frame_t            fr;
  logic              frame_rd, burst_rd;

  assign fr        = decode_frame(rx_byte);
  assign frame_rd  = (phase == PH_FRAME) && !fr.is_cmd && fr.rd;
  assign burst_rd  = (phase == PH_DATA) && rd && burst;
  assign raddr     = (phase == PH_FRAME) ? fr.field[ADDR_W-1:0]
                   : (burst ? next_addr(addr) : addr);
  assign load      = byte_done && (frame_rd || burst_rd);
  assign load_byte = rdata;
  assign we        = byte_done && (phase == PH_DATA) && !rd;
  assign waddr     = addr;
  assign wdata     = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_FRAME;
      addr     <= '0;
      rd       <= 1'b0;
      burst    <= 1'b0;
      cmd_stb  <= 1'b0;
      cmd_code <= '0;
      arg_stb  <= 1'b0;
      arg_byte <= '0;
    end else begin
      cmd_stb <= 1'b0;
      arg_stb <= 1'b0;
      if (sel_n) begin
        phase <= PH_FRAME;
      end else if (byte_done) begin
        unique case (phase)
          PH_FRAME: begin
            if (fr.is_cmd) begin
              phase    <= PH_CMD;
              cmd_stb  <= 1'b1;
              cmd_code <= fr.field;
            end else begin
              phase <= PH_DATA;
              addr  <= fr.field[ADDR_W-1:0];
              rd    <= fr.rd;
              burst <= fr.burst;
            end
          end
          PH_DATA: begin
            if (burst) addr  <= next_addr(addr);
            else       phase <= PH_FRAME;
          end
          PH_CMD: begin
            if (rx_byte[7]) begin
              cmd_stb  <= 1'b1;
              cmd_code <= rx_byte[4:0];
            end else begin
              arg_stb  <= 1'b1;
              arg_byte <= rx_byte;
            end
          end
          default: phase <= PH_FRAME;
        endcase
      end
    end
  end

  a_r2_deselect_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (phase == PH_FRAME));
  a_r9_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  a_r10_arg_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arg_stb |=> !arg_stb);
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && arg_stb));
  a_r11_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && rd) |-> !we);
  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !sel_n && phase == PH_DATA && burst)
      |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sel_n,
  input  logic       spi_clk,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       cmd_stb,
  output logic [4:0] cmd_code,
  output logic       arg_stb,
  output logic [7:0] arg_byte
);
  logic              sel_s, sclk_s, mosi_s;
  logic              byte_done, load, we;
  logic [BYTE_W-1:0] rx_byte, load_byte, rdata, wdata;
  logic [ADDR_W-1:0] raddr, waddr;

  srp_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sel_n, spi_clk, spi_mosi}),
    .q({sel_s, sclk_s, mosi_s})
  );

  srp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .load(load), .load_byte(load_byte), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(spi_miso)
  );

  srp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_s), .byte_done(byte_done),
    .rx_byte(rx_byte), .rdata(rdata), .raddr(raddr), .we(we), .waddr(waddr),
    .wdata(wdata), .load(load), .load_byte(load_byte), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .arg_stb(arg_stb), .arg_byte(arg_byte)
  );

  srp_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic       miso, cmd_stb, arg_stb;
  logic [4:0] cmd_code;
  logic [7:0] arg_byte;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { bit is_cmd; logic [7:0] val; string req; } ev_t;
  ev_t expq[$];

  always #10 clk = ~clk;

  serial_reg_port i_serial_reg_port (
    .clk(clk), .rst_n(rst_n), .spi_sel_n(sel_n), .spi_clk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .arg_stb(arg_stb), .arg_byte(arg_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input bit is_cmd, input logic [7:0] val, input string req);
    ev_t e;
    e.is_cmd = is_cmd; e.val = val; e.req = req;
    expq.push_back(e);
  endtask

  // Monitor: every strobe cycle consumes one expected event.
  always @(negedge clk) begin
    if (rst_n && (cmd_stb || arg_stb)) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9/R10: unexpected strobe cmd=%b arg=%b expected none", cmd_stb, arg_stb);
      end else begin
        ev_t e;
        e = expq.pop_front();
        check(e.req, {6'b0, cmd_stb, arg_stb}, {6'b0, e.is_cmd, !e.is_cmd});
        check(e.req, e.is_cmd ? {3'b0, cmd_code} : arg_byte, e.val);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic spi_start();
    @(negedge clk) sel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_stop();
    wait_clk(HALF);
    @(negedge clk) sel_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk) mosi = b[i];
      wait_clk(HALF);
      @(negedge clk) begin sclk = 1'b1; got[i] = miso; end
      wait_clk(HALF);
      @(negedge clk) sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] got);
    spi_bits(b, 8, got);
  endtask

  task automatic write_one(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] g;
    spi_start();
    spi_byte({3'b000, a}, g);
    spi_byte(d, g);
    spi_stop();
  endtask

  task automatic read_one(input logic [4:0] a, input logic [7:0] dummy,
                          input logic [7:0] exp, input string req);
    logic [7:0] g;
    spi_start();
    spi_byte({3'b010, a}, g);
    spi_byte(dummy, g);
    spi_stop();
    check(req, g, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    wait_clk(4);
    @(negedge clk) rst_n = 1'b1;
    wait_clk(4);
    // R12: reset state
    @(negedge clk);
    check("R12 miso", {7'b0, miso}, 8'h00);
    check("R12 strobes", {6'b0, cmd_stb, arg_stb}, 8'h00);
    read_one(5'd0, 8'h00, 8'h00, "R12 reg0");
    read_one(5'd31, 8'h00, 8'h00, "R12 reg31");

    // R1 R4: paired writes within one transaction; R5: paired reads
    spi_start();
    spi_byte(8'h03, g); spi_byte(8'hA5, g);
    spi_byte(8'h07, g); spi_byte(8'h3C, g);
    spi_stop();
    read_one(5'd3, 8'h00, 8'hA5, "R1 R4 R5 reg3");
    spi_start();
    spi_byte(8'h47, g); spi_byte(8'h00, g);
    check("R4 R5 reg7", g, 8'h3C);
    spi_byte(8'h43, g); spi_byte(8'h00, g);
    check("R5 second pair", g, 8'h A5);
    spi_stop();

    // R6 R8: burst write then burst read
    spi_start();
    spi_byte(8'h30, g);
    spi_byte(8'h11, g); spi_byte(8'h22, g); spi_byte(8'h33, g);
    spi_stop();
    spi_start();
    spi_byte(8'h70, g);
    spi_byte(8'h00, g); check("R8 burst 16", g, 8'h11);
    spi_byte(8'h00, g); check("R8 burst 17", g, 8'h22);
    spi_byte(8'h00, g); check("R6 R8 burst 18", g, 8'h33);
    spi_stop();

    // R7: wrap from 31 to 0
    spi_start();
    spi_byte(8'h3E, g);
    spi_byte(8'hE0, g); spi_byte(8'hE1, g); spi_byte(8'hE2, g);
    spi_stop();
    spi_start();
    spi_byte(8'h7E, g);
    spi_byte(8'h00, g); check("R7 reg30", g, 8'hE0);
    spi_byte(8'h00, g); check("R7 reg31", g, 8'hE1);
    spi_byte(8'h00, g); check("R7 wrap reg0", g, 8'hE2);
    spi_byte(8'h00, g); check("R7 reg1", g, 8'h00);
    spi_stop();

    // R11: host data ignored in read data bytes
    read_one(5'd3, 8'hFF, 8'hA5, "R11 dummy ff");
    spi_start();
    spi_byte(8'h70, g); spi_byte(8'h5A, g); spi_byte(8'hC3, g);
    spi_stop();
    read_one(5'd3, 8'h00, 8'hA5, "R11 reg3 kept");
    read_one(5'd16, 8'h00, 8'h11, "R11 reg16 kept");
    read_one(5'd17, 8'h00, 8'h22, "R11 reg17 kept");

    // R9 R10 R3: commands and arguments
    expect_ev(1'b1, 8'h15, "R9 cmd 15");
    expect_ev(1'b0, 8'h42, "R10 arg 42");
    expect_ev(1'b1, 8'h03, "R10 further cmd 03");
    expect_ev(1'b0, 8'h7F, "R10 arg 7f");
    spi_start();
    spi_byte(8'h95, g); spi_byte(8'h42, g); spi_byte(8'h83, g); spi_byte(8'h7F, g);
    spi_stop();
    expect_ev(1'b1, 8'h07, "R3 cmd ignores bits 6 5");
    spi_start();
    spi_byte(8'hE7, g);
    spi_stop();
    read_one(5'd7, 8'h00, 8'h3C, "R3 command leaves reg7");

    // R2: aborted partial data byte, then partial framing byte
    spi_start();
    spi_byte(8'h05, g);
    spi_bits(8'hFF, 4, g);
    spi_stop();
    read_one(5'd5, 8'h00, 8'h00, "R2 partial write dropped");
    spi_start();
    spi_bits(8'hFF, 3, g);
    spi_stop();
    expect_ev(1'b1, 8'h01, "R2 realigned framing");
    spi_start();
    spi_byte(8'h81, g);
    spi_stop();
    write_one(5'd5, 8'h77);
    read_one(5'd5, 8'h00, 8'h77, "R1 R2 write after abort");

    wait_clk(20);
    check("R9 R10 all strobes seen", 8'(expq.size()), 8'h00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule